// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a counter-based timer that software programs through a small register port. Once the enable bit is set, the count advances by one on every cycle in which the tick input is high. When the advanced count exceeds the programmed compare value, the timer records a compare event. Exceeding means strictly greater: equal is not enough. A compare event sets a sticky status flag and, if interrupts are allowed, latches a pending interrupt that drives the request output.

A control bit selects what the counter does at the event. In one-shot-period mode it restarts from zero. In free-running mode it keeps counting and wraps from all ones to zero. A separate expire input forces a compare event at once, whatever the count, as long as the timer is enabled. Software clears the flag by reading the status register while the flag is set and then writing a zero to the flag bit. A compare event in the same cycle as that write wins, so no event is lost.

Top module: `cmt_timer`

## Requirements
- R1: After reset, the count reads 0, the compare register reads all ones, control reads 0, status reads 0 and `irq` is low.
- R2: The count rises by exactly one per cycle with `tick` high only while control bit 0 (enable) is 1. With enable at 0, ticks leave the count unchanged.
- R3: A compare event happens on an advancing tick when the advanced count is strictly greater than the compare register. It sets status bit 0. An advanced count equal to the compare value causes no event.
- R4: With control bit 1 (free-run) at 0, the count becomes 0 in the cycle of a compare event.
- R5: With free-run at 1, the count keeps its advanced value at an event. The count wraps from all ones to 0. With compare at all ones, no tick-driven event can happen.
- R6: At a compare event with control bit 2 (interrupt enable) at 1, status bit 1 (pending) sets and `irq` goes high. With control bit 2 at 0, the event leaves `irq` low.
- R7: A cycle with `expire` high and enable at 1 is a compare event for any count. With enable at 0, `expire` has no effect.
- R8: Writing status with bit 0 at 0 clears status bits 0 and 1 only if a status read saw bit 0 set since the last status write. Without that read, the write leaves the flag set.
- R9: A compare event in the same cycle as a clearing status write leaves status bit 0 set.
- R10: Register addresses are 0 control, 1 count, 2 compare and 3 status. Writes to the count register load the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for the selected register |
| tick | input | 1 | Count-advance qualifier |
| expire | input | 1 | Forces a compare event |
| irq | output | 1 | Interrupt request, high while pending |

## Verification
The counter runs with compare values that put the boundary just below, at and just past the count. This separates a strictly-greater test from a greater-or-equal test. The same thresholds are run in restart mode and in free-running mode, which shows whether the count resets to zero or keeps advancing, and a run across the top of the count range confirms the wrap. Interrupt enable on and off, the expire input with the timer enabled and disabled, clearing writes with and without the preceding read, and a clearing write that coincides with an event each isolate one control path.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_CMP   = 2'd2,
      SEL_STAT  = 2'd3
   } reg_sel_e;

   // control layout: bit0 enable, bit1 free-run, bit2 interrupt enable
   typedef struct packed {
      logic ien;
      logic fr;
      logic en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cmt_counter.sv
module cmt_counter
   import cmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctrl_t            ctrl,
   input  logic [CNT_W-1:0] cmp,
   input  logic             tick,
   input  logic             expire,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             evt
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             adv;
   logic             over;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W-1:0] count_d;

   assign adv  = ctrl.en & tick;
   assign nxt  = count + ONE;
   assign over = adv & (nxt > cmp);
   assign evt  = ctrl.en & (expire | over);

   always_comb begin
      count_d = count;
      if (load)
         count_d = load_val;
      else if (evt && !ctrl.fr)
         count_d = '0;
      else if (adv)
         count_d = nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else
         count <= count_d;
   end

endmodule

// File: rtl/cmt_status.sv
module cmt_status (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic ien,
   input  logic stat_rd,
   input  logic stat_wr,
   input  logic wbit0,
   output logic comp,
   output logic pend
);

   logic armed;
   logic clr;

   assign clr = stat_wr & armed & ~wbit0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         comp  <= 1'b0;
         pend  <= 1'b0;
      end else begin
         if (stat_rd && comp)
            armed <= 1'b1;
         else if (stat_wr)
            armed <= 1'b0;

         if (evt)
            comp <= 1'b1;
         else if (clr)
            comp <= 1'b0;

         if (evt && ien)
            pend <= 1'b1;
         else if (clr)
            pend <= 1'b0;
      end
   end

endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
   import cmt_pkg::*;
#(
   parameter int               CNT_W   = 16,
   parameter logic [CNT_W-1:0] CMP_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [CNT_W-1:0] reg_wdata,
   input  logic [CNT_W-1:0] count,
   input  logic             comp,
   input  logic             pend,
   output ctrl_t            ctrl,
   output logic [CNT_W-1:0] cmp,
   output logic             cnt_wr,
   output logic             stat_wr,
   output logic             stat_rd,
   output logic [CNT_W-1:0] reg_rdata
);

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_addr);

   assign cnt_wr  = reg_wr & (sel == SEL_COUNT);
   assign stat_wr = reg_wr & (sel == SEL_STAT);
   assign stat_rd = reg_rd & (sel == SEL_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         cmp  <= CMP_RST;
      end else if (reg_wr) begin
         if (sel == SEL_CTRL)
            ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (sel == SEL_CMP)
            cmp <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl;
         SEL_COUNT: reg_rdata = count;
         SEL_CMP:   reg_rdata = cmp;
         SEL_STAT:  reg_rdata[1:0] = {pend, comp};
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
   import cmt_pkg::*;
#(
   parameter int               CNT_W   = 16,
   parameter logic [CNT_W-1:0] CMP_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic             tick,
   input  logic             expire,
   output logic             irq
);

   generate
      if (CNT_W < CTRL_W || CNT_W > 32) begin : g_bad_width
         $error("cmt_timer: CNT_W must lie between CTRL_W and 32");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] count_q;
   logic             evt;
   logic             comp_q;
   logic             pend_q;
   logic             cnt_wr;
   logic             stat_wr;
   logic             stat_rd;
   logic             en_w;
   logic             fr_w;
   logic             ien_w;
   logic             wbit0;

   assign en_w  = ctrl_q.en;
   assign fr_w  = ctrl_q.fr;
   assign ien_w = ctrl_q.ien;
   assign wbit0 = reg_wdata[0];

   cmt_regs #(.CNT_W(CNT_W), .CMP_RST(CMP_RST)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .count     (count_q),
      .comp      (comp_q),
      .pend      (pend_q),
      .ctrl      (ctrl_q),
      .cmp       (cmp_q),
      .cnt_wr    (cnt_wr),
      .stat_wr   (stat_wr),
      .stat_rd   (stat_rd),
      .reg_rdata (reg_rdata)
   );

   cmt_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl     (ctrl_q),
      .cmp      (cmp_q),
      .tick     (tick),
      .expire   (expire),
      .load     (cnt_wr),
      .load_val (reg_wdata),
      .count    (count_q),
      .evt      (evt)
   );

   cmt_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .ien     (ien_w),
      .stat_rd (stat_rd),
      .stat_wr (stat_wr),
      .wbit0   (wbit0),
      .comp    (comp_q),
      .pend    (pend_q)
   );

   assign irq = pend_q;

endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             evt,
   input logic             comp,
   input logic             irq,
   input logic [CNT_W-1:0] count,
   input logic             en,
   input logic             fr,
   input logic             ien,
   input logic             cnt_wr,
   input logic             stat_wr,
   input logic             wbit0
);

   // R3
   evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> comp);

   // R4
   restart_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !fr && !cnt_wr) |=> (count == '0));

   // R2
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cnt_wr) |=> $stable(count));

   // R6
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(evt && ien));

   // R8
   flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(comp) |-> $past(stat_wr && !wbit0));

   // R9
   evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && stat_wr) |=> comp);

endmodule

bind cmt_timer cmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt     (evt),
   .comp    (comp_q),
   .irq     (irq),
   .count   (count_q),
   .en      (en_w),
   .fr      (fr_w),
   .ien     (ien_w),
   .cnt_wr  (cnt_wr),
   .stat_wr (stat_wr),
   .wbit0   (wbit0)
);

// File: tb/test_cmt_timer.sv
module test_cmt_timer;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic         reg_rd = 1'b0;
   logic [1:0]   reg_addr = 2'd0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         tick = 1'b0;
   logic         expire = 1'b0;
   logic         irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   cmt_timer #(.CNT_W(W)) i_cmt_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tick      (tick),
      .expire    (expire),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
      end
      tick = 1'b0;
   endtask

   task automatic clear_flag();
      logic [W-1:0] v;
      rd(2'd3, v);
      wr(2'd3, '0);
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
      rd(2'd1, v); check("R1 count", v, 16'h0000);
      rd(2'd2, v); check("R1 compare", v, 16'hFFFF);
      rd(2'd3, v); check("R1 status", v, 16'h0000);
      check("R1 irq", {15'd0, irq}, 16'd0);
   endtask

   task automatic t_enable();
      logic [W-1:0] v;
      ticks(3);
      rd(2'd1, v); check("R2 disabled ticks ignored", v, 16'd0);
      wr(2'd0, 16'h0001);
      ticks(3);
      rd(2'd1, v); check("R2 enabled count", v, 16'd3);
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'd0);
      rd(2'd1, v); check("R10 count load", v, 16'd0);
   endtask

   task automatic t_restart();
      logic [W-1:0] v;
      wr(2'd2, 16'd3);
      wr(2'd0, 16'h0001);
      ticks(3);
      rd(2'd1, v); check("R3 equal no event count", v, 16'd3);
      rd(2'd3, v); check("R3 equal no event flag", v, 16'd0);
      ticks(1);
      check("R6 irq off without enable", {15'd0, irq}, 16'd0);
      rd(2'd1, v); check("R4 restart to zero", v, 16'd0);
      wr(2'd3, 16'd0);
      rd(2'd3, v); check("R8 unarmed write keeps flag", v, 16'h0001);
      wr(2'd3, 16'd0);
      rd(2'd3, v); check("R8 armed write clears", v, 16'h0000);
   endtask

   task automatic t_freerun();
      logic [W-1:0] v;
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'd0);
      wr(2'd2, 16'd5);
      wr(2'd0, 16'h0003);
      ticks(6);
      rd(2'd1, v); check("R5 free-run keeps count", v, 16'd6);
      rd(2'd3, v); check("R3 free-run flag", v, 16'h0001);
      wr(2'd3, 16'd0);
      wr(2'd2, 16'hFFFF);
      wr(2'd1, 16'hFFFE);
      ticks(2);
      rd(2'd1, v); check("R5 wrap", v, 16'd0);
      rd(2'd3, v); check("R5 no event at wrap", v, 16'd0);
   endtask

   task automatic t_irq();
      logic [W-1:0] v;
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'd0);
      wr(2'd2, 16'd1);
      wr(2'd0, 16'h0005);
      ticks(1);
      check("R6 irq before event", {15'd0, irq}, 16'd0);
      ticks(1);
      check("R6 irq raised", {15'd0, irq}, 16'd1);
      rd(2'd3, v); check("R6 pending status", v, 16'h0003);
      wr(2'd3, 16'd0);
      check("R8 irq cleared", {15'd0, irq}, 16'd0);
   endtask

   task automatic t_expire();
      logic [W-1:0] v;
      wr(2'd0, 16'h0001);
      wr(2'd2, 16'd100);
      wr(2'd1, 16'd7);
      expire = 1'b1; @(negedge clk); expire = 1'b0;
      rd(2'd3, v); check("R7 forced flag", v, 16'h0001);
      rd(2'd1, v); check("R7 forced restart", v, 16'd0);
      wr(2'd3, 16'd0);
      wr(2'd0, 16'h0003);
      wr(2'd1, 16'd9);
      expire = 1'b1; @(negedge clk); expire = 1'b0;
      rd(2'd1, v); check("R7 forced free-run count", v, 16'd9);
      clear_flag();
      wr(2'd0, 16'h0000);
      expire = 1'b1; @(negedge clk); expire = 1'b0;
      rd(2'd3, v); check("R7 disabled expire ignored", v, 16'd0);
   endtask

   task automatic t_race();
      logic [W-1:0] v;
      wr(2'd1, 16'd0);
      wr(2'd2, 16'd0);
      wr(2'd0, 16'h0001);
      ticks(1);
      rd(2'd3, v); check("R9 setup flag", v, 16'h0001);
      reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = '0; tick = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; tick = 1'b0;
      rd(2'd3, v); check("R9 event beats clear", v, 16'h0001);
      wr(2'd3, 16'd0);
      rd(2'd3, v); check("R9 later clear", v, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_restart();
      t_freerun();
      t_irq();
      t_expire();
      t_race();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule